// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Infrared Pulse Shaping

This block sends characters on one asynchronous serial line. A one-byte holding buffer accepts a byte from a simple write strobe. When the shifter is free, the byte moves into a shift register and goes out as a character frame. The frame has a start bit, 7 or 8 data bits sent least significant bit first, an optional parity bit and one or two stop bits. Every bit lasts sixteen pulses of a 16x oversampling tick that an outside baud generator supplies.

Because of the buffer, a second byte can wait while the first one is being shifted out. The block raises two separate one-cycle events. The first says that the holding buffer has emptied into the shifter and can take another byte. The second says that the line has really gone idle with nothing left to send. An optional infrared mode turns each zero bit into a short low pulse, and that pulse can be inverted for the optical driver.

Top module: `uart_irtx`

## Requirements
- R1: A write (`wr_en` high) while `buf_full` is low stores `wr_data` and sets `buf_full`. When the shifter is idle, a full buffer moves into the shifter on the next clock edge and `buf_full` clears.
- R2: The frame is one 0 start bit, then the data bits LSB first (8 bits if `len8`=1, else 7 bits, `wr_data[6:0]`), then a parity bit if `par_en`=1, then one stop bit of value 1, or two if `stop2`=1. Parity is the XOR of the sent data bits when `par_odd`=0 (even) and its inverse when `par_odd`=1 (odd). Format inputs are sampled when the byte moves into the shifter.
- R3: `tbe_evt` pulses high for one cycle, in the cycle after a byte moves from the buffer into the shifter.
- R4: `tend_evt` pulses for one cycle when the last stop bit ends and the buffer is empty. It stays low when a byte is waiting.
- R5: `busy` is high from the load of the shift register until the final stop bit ends. Each bit lasts exactly 16 cycles of `tick16`.
- R6: A write while `buf_full` is high is ignored: the waiting byte is kept and no extra frame is sent.
- R7: With `ir_en`=1 and `ir_inv`=0, a 0 bit drives the line low only during oversample phases 6, 7 and 8 of its bit (phase 0 is the first tick period of the bit). A 1 bit and the idle line stay high.
- R8: With `ir_en`=1, `ir_inv`=1 inverts the whole output. With `ir_en`=0, `ir_inv` has no effect.
- R9: `soft_rst` clears the buffer, the shifter, `busy` and both events on the next clock edge, and the output returns to its idle level.
- R10: With `ir_en`=0 the line carries the frame bits unmodified and idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of all transmit state |
| tick16 | input | 1 | One-cycle pulse at 16 times the baud rate |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to queue |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| ir_en | input | 1 | Select infrared pulse shaping |
| ir_inv | input | 1 | Invert the output in infrared mode |
| tx_out | output | 1 | Serial line |
| busy | output | 1 | Shifter active |
| buf_full | output | 1 | Holding buffer occupied |
| tbe_evt | output | 1 | Buffer-empty event pulse |
| tend_evt | output | 1 | End-of-transmission event pulse |

## Verification
The assertions assume that `ir_en` and `ir_inv` stay constant while a frame is on the line. They also assume that `tick16` is a single-cycle pulse and never stays high for two cycles in a row. The bench changes its randomly drawn format and infrared settings only when the block is idle. It drives `tick16` as a one-cycle pulse every fourth clock and makes writes only as single-cycle strobes.

// File: rtl/uart_irtx.sv
module uart_irtx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       len8,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop2,
  input  logic       ir_en,
  input  logic       ir_inv,
  output logic       tx_out,
  output logic       busy,
  output logic       buf_full,
  output logic       tbe_evt,
  output logic       tend_evt
);
  logic [7:0]  hold;
  logic [11:0] sh, frame;
  logic [3:0]  left, phase, nbits;

  wire       move   = buf_full & ~busy;
  wire       accept = wr_en & ~buf_full;
  wire       last   = busy & tick16 & (phase == 4'd15) & (left == 4'd1);
  wire [7:0] dsent  = len8 ? hold : {1'b0, hold[6:0]};
  wire       par    = ^dsent ^ par_odd;

  assign nbits = 4'd9 + {3'b0, len8} + {3'b0, par_en} + {3'b0, stop2};

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || len8) frame[1+i] = hold[i];
    if (par_en) frame[len8 ? 9 : 8] = par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; buf_full <= 1'b0; busy <= 1'b0; sh <= '1;
      left <= '0; phase <= '0; tbe_evt <= 1'b0; tend_evt <= 1'b0;
    end else if (soft_rst) begin
      buf_full <= 1'b0; busy <= 1'b0; sh <= '1;
      left <= '0; phase <= '0; tbe_evt <= 1'b0; tend_evt <= 1'b0;
    end else begin
      tbe_evt  <= move;
      tend_evt <= last & ~buf_full;
      buf_full <= (buf_full & ~move) | accept;
      if (accept) hold <= wr_data;
      if (move) begin
        sh <= frame; left <= nbits; phase <= '0; busy <= 1'b1;
      end else if (busy && tick16) begin
        phase <= phase + 4'd1;
        if (phase == 4'd15) begin
          sh   <= {1'b1, sh[11:1]};
          left <= left - 4'd1;
          if (left == 4'd1) busy <= 1'b0;
        end
      end
    end
  end

  wire bitv  = busy ? sh[0] : 1'b1;
  wire ir_lo = ~bitv & (phase >= 4'd6) & (phase <= 4'd8);
  assign tx_out = ir_en ? (~ir_lo ^ ir_inv) : bitv;
endmodule

// File: rtl/uart_irtx_chk.sv
module uart_irtx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       wr_en,
  input logic       ir_en,
  input logic       ir_inv,
  input logic       tx_out,
  input logic       busy,
  input logic       buf_full,
  input logic       tbe_evt,
  input logic       tend_evt,
  input logic [3:0] phase
);
  p_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && buf_full && wr_en && !soft_rst |=> buf_full);
  p_tbe_with_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tbe_evt |-> busy);
  p_tend_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tend_evt |-> !busy);
  p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy && !buf_full && !tbe_evt && !tend_evt);
  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ir_en |-> tx_out);
  p_pulse_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ir_en && (tx_out == ir_inv) |-> busy && phase >= 4'd6 && phase <= 4'd8);
  p_load_from_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(buf_full));
endmodule

bind uart_irtx uart_irtx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
  .ir_en(ir_en), .ir_inv(ir_inv), .tx_out(tx_out), .busy(busy),
  .buf_full(buf_full), .tbe_evt(tbe_evt), .tend_evt(tend_evt), .phase(phase)
);

// File: tb/sim_uart_irtx.sv
`timescale 1ns/1ps
module sim_uart_irtx;
  logic clk = 0, rst_n = 0, soft_rst = 0, wr_en = 0;
  logic len8 = 1, par_en = 0, par_odd = 0, stop2 = 0, ir_en = 0, ir_inv = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] tcnt = 0;
  logic tx_out, busy, buf_full, tbe_evt, tend_evt;
  wire  tick16 = (tcnt == 2'd0);
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 2'd1;

  uart_irtx u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] build(input logic [7:0] d);
    logic [11:0] f = '1;
    int dl = len8 ? 8 : 7;
    logic p = par_odd;
    f[0] = 1'b0;
    for (int i = 0; i < dl; i++) begin f[1+i] = d[i]; p ^= d[i]; end
    if (par_en) f[1+dl] = p;
    return f;
  endfunction

  function automatic int nbits();
    return 1 + (len8 ? 8 : 7) + int'(par_en) + 1 + int'(stop2);
  endfunction

  function automatic logic line(input logic b, input int ph);
    logic lo = !b && ph >= 6 && ph <= 8;
    return ir_en ? (!lo ^ ir_inv) : b;
  endfunction

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic expect_frame(input logic [7:0] d, input bit exp_tend);
    logic [11:0] f = build(d);
    int n = nbits(), b = 0, ph = 0, errs = 0, wt = 0;
    bit adv;
    while (!busy && wt < 200) begin @(negedge clk); wt++; end
    check(busy === 1, "R5 busy rises after load", busy, 1);
    check(tbe_evt === 1, "R3 tbe pulse at load", tbe_evt, 1);
    while (b < n) begin
      if (tx_out !== line(f[b], ph) || busy !== 1) errs++;
      adv = tick16;
      @(negedge clk);
      if (adv) begin ph++; if (ph == 16) begin ph = 0; b++; end end
    end
    check(errs == 0, "R2/R7/R8/R10 line waveform", errs, 0);
    check(busy === 0, "R5 busy ends with last stop bit", busy, 0);
    check(tend_evt === exp_tend, "R4 end-of-transmission event", tend_evt, exp_tend);
  endtask

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd1234);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(tx_out === 1 && busy === 0 && buf_full === 0, "R10 reset idle", tx_out, 1);
    check(tbe_evt === 0 && tend_evt === 0, "R3 no events after reset", tbe_evt, 0);

    ir_inv = 1;
    @(negedge clk);
    check(tx_out === 1, "R8 inversion ignored without ir mode", tx_out, 1);
    ir_en = 1;
    @(negedge clk);
    check(tx_out === 0, "R8 inverted idle in ir mode", tx_out, 0);
    ir_en = 0; ir_inv = 0;

    len8 = 1; par_en = 0; stop2 = 0;
    write(8'h00);
    expect_frame(8'h00, 1);
    len8 = 0; par_en = 1; par_odd = 1; stop2 = 1;
    write(8'hFF);
    expect_frame(8'hFF, 1);
    ir_en = 1;
    write(8'h5A);
    expect_frame(8'h5A, 1);
    ir_en = 0;

    len8 = 1; par_en = 1; par_odd = 0; stop2 = 0;
    fork
      expect_frame(8'hA5, 0);
      begin
        repeat (10) @(negedge clk);
        write(8'h3C);
        check(buf_full === 1, "R1 queued byte sets buf_full", buf_full, 1);
        write(8'hC3);
        check(buf_full === 1, "R6 write while full keeps buffer", buf_full, 1);
      end
      write(8'hA5);
    join
    check(busy === 0, "R5 gap before queued frame", busy, 0);
    expect_frame(8'h3C, 1);
    repeat (300) @(negedge clk);
    check(busy === 0 && buf_full === 0, "R6 no frame for ignored write", busy, 0);

    write(8'h81);
    repeat (40) @(negedge clk);
    check(busy === 1, "R9 frame running before soft reset", busy, 1);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    check(busy === 0 && buf_full === 0 && tx_out === 1, "R9 soft reset clears", busy, 0);
    repeat (300) @(negedge clk);
    check(busy === 0 && tx_out === 1, "R9 stays idle", busy, 0);

    for (int k = 0; k < 20; k++) begin
      logic [7:0] d = 8'($urandom);
      len8 = 1'($urandom); par_en = 1'($urandom); par_odd = 1'($urandom);
      stop2 = 1'($urandom); ir_en = 1'($urandom); ir_inv = 1'($urandom);
      write(d);
      expect_frame(d, 1);
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule